// File: doc/BRIEF.md
# Privilege Stack Trap Controller

This block holds a hart's current privilege level and interrupt enable together with two saved copies, arranged as a three-entry stack. Every cycle it looks at the pending interrupt sources, the enable mask and the current privilege and interrupt-enable state, and decides whether a trap must be taken. A synchronous exception request always causes a trap. When a trap is taken it pushes the stack, loads the trap target address and the cause value, and pulses a strobe. A return request pops the stack and refills the deepest entry with fixed values.

The block also keeps the machine timer-compare register. It raises the machine timer-pending flag when the free-running real-time count reaches the compare value. An inter-processor strobe sets a machine software-pending flag, which a separate input clears. The surrounding pipeline uses `trap_o`, `pc_o` and `cause_o` to redirect fetch. It reads the stack fields to know the current privilege.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset `pc_o` = VEC_BASE + 0x100, the current privilege is machine (3), both saved privileges are supervisor (1), all three enables, `mprv_o`, `trap_o`, `msip_o`, `mtip_o` are 0, and the compare register holds all ones. Privilege codes: user=0, supervisor=1, machine=3.
- R2: On a taken trap, level 1 moves to level 2 and the current entry moves to level 1 (privilege and enable each). The current privilege becomes machine, the current enable becomes 0 and `mprv_o` is cleared.
- R3: On a return with no trap in the same cycle, level 1 moves to current and level 2 moves to level 1. Level 2 is refilled with privilege user and enable 1.
- R4: `trap_o`, `pc_o` and `cause_o` change on the clock edge that samples the trap condition. `pc_o` = VEC_BASE + 0x40 × (privilege current before the trap). `trap_o` is high for one cycle per trap.
- R5: Machine-level sources (machine software, machine timer, host message) are eligible when the current privilege is below machine, or when it is machine and the current enable is 1.
- R6: Supervisor-level sources (supervisor software, supervisor timer) are eligible when the current privilege is user, or when it is supervisor and the current enable is 1.
- R7: Priority from highest to lowest: machine software, machine timer, host message, supervisor software, supervisor timer. The interrupt codes are software=0, timer=1, host=2.
- R8: For an interrupt, `cause_o` has its MSB set and the code in its low bits. For an exception, `cause_o` is {0, `exc_cause_i`}.
- R9: An exception requested in the same cycle as an eligible interrupt is taken instead of the interrupt. A trap in the same cycle as a return takes precedence, and no pop happens.
- R10: `mtip_o` becomes 1 on the edge after a cycle in which `rtc_i` ≥ the compare value and no write occurs. A compare write clears `mtip_o` on its edge. The new value is compared from the next cycle.
- R11: `ipi_i` sets `msip_o` on the next edge. `msip_clr_i` clears it. When both arrive together, the set wins.
- R12: `irq_en_i` bit 0 enables machine software, bit 1 machine timer, bit 2 supervisor software and bit 3 supervisor timer. A source counts only when its enable bit is 1. The host message has no enable bit and is never masked by `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_i | input | TIME_W | Real-time count |
| cmp_we_i | input | 1 | Timer-compare write strobe |
| cmp_wdata_i | input | TIME_W | Timer-compare write value |
| ipi_i | input | 1 | Inter-processor interrupt strobe |
| msip_clr_i | input | 1 | Clear machine software pending |
| host_pend_i | input | 1 | Host message pending (level) |
| s_sw_pend_i | input | 1 | Supervisor software pending (level) |
| s_tm_pend_i | input | 1 | Supervisor timer pending (level) |
| irq_en_i | input | 4 | Interrupt enable mask |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | XLEN-1 | Exception cause code |
| ret_req_i | input | 1 | Trap return request |
| mprv_set_i | input | 1 | Set modify-privilege flag |
| pc_o | output | XLEN | Trap target PC |
| cause_o | output | XLEN | Cause of the last trap |
| trap_o | output | 1 | Trap-taken strobe |
| priv_o | output | 2 | Current privilege |
| ie_o | output | 1 | Current interrupt enable |
| priv1_o | output | 2 | Saved privilege, level 1 |
| ie1_o | output | 1 | Saved enable, level 1 |
| priv2_o | output | 2 | Saved privilege, level 2 |
| ie2_o | output | 1 | Saved enable, level 2 |
| mprv_o | output | 1 | Modify-privilege flag |
| msip_o | output | 1 | Machine software pending |
| mtip_o | output | 1 | Machine timer pending |

## Verification
On every cycle, the assertions check the stack push and pop movements and the machine-mode mask with the enable clear. They also check the trap vector against the prior privilege, that an exception's cause overrides an interrupt's, and the compare-register set and clear rules. Only the directed scenarios can show other behaviour: the full priority order across five sources, the enable-mask mapping, and the supervisor eligibility rule. The same holds for the exact stack contents after chains of returns and the equality boundary of the timer compare.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  typedef struct packed {
    priv_e priv;
    logic  ie;
  } stk_ent_t;

  localparam int STACK_DEPTH = 3;
  localparam int EN_W        = 4;
  localparam int CODE_W      = 2;

  // enable mask bit positions
  localparam int EN_M_SW = 0;
  localparam int EN_M_TM = 1;
  localparam int EN_S_SW = 2;
  localparam int EN_S_TM = 3;

  localparam logic [CODE_W-1:0] IRQ_SW   = 2'd0;
  localparam logic [CODE_W-1:0] IRQ_TM   = 2'd1;
  localparam logic [CODE_W-1:0] IRQ_HOST = 2'd2;
endpackage

// File: rtl/priv_stack.sv
module priv_stack
  import priv_trap_pkg::*;
#(
  parameter int DEPTH = STACK_DEPTH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  push_i,
  input  logic                  pop_i,
  output stk_ent_t [DEPTH-1:0]  ent_o
);
  localparam stk_ent_t TOP_PUSH = '{priv: PRIV_M, ie: 1'b0};
  localparam stk_ent_t REFILL   = '{priv: PRIV_U, ie: 1'b1};

  stk_ent_t [DEPTH-1:0] ent_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    stk_ent_t push_v, pop_v, rst_v;

    if (i == 0) begin : g_top
      assign push_v = TOP_PUSH;
      assign rst_v  = '{priv: PRIV_M, ie: 1'b0};
    end else begin : g_lower
      assign push_v = ent_q[i-1];
      assign rst_v  = '{priv: PRIV_S, ie: 1'b0};
    end

    if (i == DEPTH-1) begin : g_deep
      assign pop_v = REFILL;
    end else begin : g_shallow
      assign pop_v = ent_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q[i] <= rst_v;
      else if (push_i) ent_q[i] <= push_v;
      else if (pop_i)  ent_q[i] <= pop_v;
    end
  end

  assign ent_o = ent_q;

  assert_push_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (ent_q[0].priv == PRIV_M) && !ent_q[0].ie && (ent_q[1] == $past(ent_q[0])));

  assert_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (ent_q[0] == $past(ent_q[1])) &&
                           (ent_q[DEPTH-1].priv == PRIV_U) && ent_q[DEPTH-1].ie);
endmodule

// File: rtl/irq_select.sv
module irq_select
  import priv_trap_pkg::*;
(
  input  priv_e             priv_i,
  input  logic              ie_i,
  input  logic              m_sw_i,
  input  logic              m_tm_i,
  input  logic              host_i,
  input  logic              s_sw_i,
  input  logic              s_tm_i,
  input  logic [EN_W-1:0]   en_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic m_ok, s_ok;
  logic req_m_sw, req_m_tm, req_host, req_s_sw, req_s_tm;

  assign m_ok = (priv_i != PRIV_M) || ie_i;
  assign s_ok = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && ie_i);

  assign req_m_sw = m_ok && m_sw_i && en_i[EN_M_SW];
  assign req_m_tm = m_ok && m_tm_i && en_i[EN_M_TM];
  assign req_host = m_ok && host_i;
  assign req_s_sw = s_ok && s_sw_i && en_i[EN_S_SW];
  assign req_s_tm = s_ok && s_tm_i && en_i[EN_S_TM];

  always_comb begin
    valid_o = 1'b1;
    code_o  = IRQ_SW;
    if      (req_m_sw) code_o = IRQ_SW;
    else if (req_m_tm) code_o = IRQ_TM;
    else if (req_host) code_o = IRQ_HOST;
    else if (req_s_sw) code_o = IRQ_SW;
    else if (req_s_tm) code_o = IRQ_TM;
    else               valid_o = 1'b0;
  end
endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
  parameter int TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] rtc_i,
  input  logic              we_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic              mtip_o
);
  logic [TIME_W-1:0] cmp_q;
  logic              mtip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      mtip_q <= 1'b0;
    end else if (we_i) begin
      cmp_q  <= wdata_i;
      mtip_q <= 1'b0;
    end else if (rtc_i >= cmp_q) begin
      mtip_q <= 1'b1;
    end
  end

  assign mtip_o = mtip_q;

  assert_cmp_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !mtip_o);

  assert_cmp_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && (rtc_i >= cmp_q)) |=> mtip_o);
endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter int               TIME_W   = 32,
  parameter logic [XLEN-1:0]  VEC_BASE = 32'h1000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] rtc_i,
  input  logic              cmp_we_i,
  input  logic [TIME_W-1:0] cmp_wdata_i,
  input  logic              ipi_i,
  input  logic              msip_clr_i,
  input  logic              host_pend_i,
  input  logic              s_sw_pend_i,
  input  logic              s_tm_pend_i,
  input  logic [3:0]        irq_en_i,
  input  logic              exc_req_i,
  input  logic [XLEN-2:0]   exc_cause_i,
  input  logic              ret_req_i,
  input  logic              mprv_set_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   cause_o,
  output logic              trap_o,
  output logic [1:0]        priv_o,
  output logic              ie_o,
  output logic [1:0]        priv1_o,
  output logic              ie1_o,
  output logic [1:0]        priv2_o,
  output logic              ie2_o,
  output logic              mprv_o,
  output logic              msip_o,
  output logic              mtip_o
);
  localparam logic [XLEN-1:0] RST_PC = VEC_BASE + XLEN'(256);

  stk_ent_t [STACK_DEPTH-1:0] ent;
  logic                       take, pop, irq_valid, msip_q, mprv_q, mtip;
  logic [CODE_W-1:0]          irq_code;
  logic [XLEN-1:0]            vec_d, cause_d, pc_q, cause_q;
  logic                       trap_q;

  assign take = exc_req_i || irq_valid;
  assign pop  = ret_req_i && !take;

  priv_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .pop_i  (pop),
    .ent_o  (ent)
  );

  irq_select u_irq (
    .priv_i  (ent[0].priv),
    .ie_i    (ent[0].ie),
    .m_sw_i  (msip_q),
    .m_tm_i  (mtip),
    .host_i  (host_pend_i),
    .s_sw_i  (s_sw_pend_i),
    .s_tm_i  (s_tm_pend_i),
    .en_i    (irq_en_i),
    .valid_o (irq_valid),
    .code_o  (irq_code)
  );

  mtimer_cmp #(.TIME_W(TIME_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rtc_i   (rtc_i),
    .we_i    (cmp_we_i),
    .wdata_i (cmp_wdata_i),
    .mtip_o  (mtip)
  );

  assign vec_d   = VEC_BASE + (XLEN'(ent[0].priv) << 6);
  assign cause_d = exc_req_i ? {1'b0, exc_cause_i}
                             : {1'b1, {(XLEN-1-CODE_W){1'b0}}, irq_code};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RST_PC;
      cause_q <= '0;
      trap_q  <= 1'b0;
      msip_q  <= 1'b0;
      mprv_q  <= 1'b0;
    end else begin
      trap_q <= take;
      if (take) begin
        pc_q    <= vec_d;
        cause_q <= cause_d;
      end
      if (ipi_i)           msip_q <= 1'b1;
      else if (msip_clr_i) msip_q <= 1'b0;
      if (take)            mprv_q <= 1'b0;
      else if (mprv_set_i) mprv_q <= 1'b1;
    end
  end

  assign pc_o    = pc_q;
  assign cause_o = cause_q;
  assign trap_o  = trap_q;
  assign priv_o  = ent[0].priv;
  assign ie_o    = ent[0].ie;
  assign priv1_o = ent[1].priv;
  assign ie1_o   = ent[1].ie;
  assign priv2_o = ent[2].priv;
  assign ie2_o   = ent[2].ie;
  assign mprv_o  = mprv_q;
  assign msip_o  = msip_q;
  assign mtip_o  = mtip;

  assert_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> trap_o && (pc_o == VEC_BASE + (XLEN'($past(priv_o)) << 6)));

  assert_trap_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (priv_o == 2'd3) && !ie_o && !mprv_o);

  assert_m_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((priv_o == 2'd3) && !ie_o && !exc_req_i) |=> !trap_o);

  assert_exc_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_i |=> !cause_o[XLEN-1] && (cause_o[XLEN-2:0] == $past(exc_cause_i)));

  assert_ipi_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_i |=> msip_o);
endmodule

// File: tb/priv_trap_ctrl_tb.sv
module priv_trap_ctrl_tb;
  localparam logic [31:0] BASE = 32'h1000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] rtc_i = '0;
  logic        cmp_we_i = 1'b0;
  logic [31:0] cmp_wdata_i = '0;
  logic        ipi_i = 1'b0, msip_clr_i = 1'b0, host_pend_i = 1'b0;
  logic        s_sw_pend_i = 1'b0, s_tm_pend_i = 1'b0;
  logic [3:0]  irq_en_i = '0;
  logic        exc_req_i = 1'b0;
  logic [30:0] exc_cause_i = '0;
  logic        ret_req_i = 1'b0, mprv_set_i = 1'b0;
  logic [31:0] pc_o, cause_o;
  logic        trap_o, ie_o, ie1_o, ie2_o, mprv_o, msip_o, mtip_o;
  logic [1:0]  priv_o, priv1_o, priv2_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  priv_trap_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rtc_i(rtc_i), .cmp_we_i(cmp_we_i),
    .cmp_wdata_i(cmp_wdata_i), .ipi_i(ipi_i), .msip_clr_i(msip_clr_i),
    .host_pend_i(host_pend_i), .s_sw_pend_i(s_sw_pend_i), .s_tm_pend_i(s_tm_pend_i),
    .irq_en_i(irq_en_i), .exc_req_i(exc_req_i), .exc_cause_i(exc_cause_i),
    .ret_req_i(ret_req_i), .mprv_set_i(mprv_set_i), .pc_o(pc_o), .cause_o(cause_o),
    .trap_o(trap_o), .priv_o(priv_o), .ie_o(ie_o), .priv1_o(priv1_o), .ie1_o(ie1_o),
    .priv2_o(priv2_o), .ie2_o(ie2_o), .mprv_o(mprv_o), .msip_o(msip_o), .mtip_o(mtip_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_stack(string req, int p0, int e0, int p1, int e1, int p2, int e2);
    chk({req, " priv"},  32'(priv_o),  32'(p0));
    chk({req, " ie"},    32'(ie_o),    32'(e0));
    chk({req, " priv1"}, 32'(priv1_o), 32'(p1));
    chk({req, " ie1"},   32'(ie1_o),   32'(e1));
    chk({req, " priv2"}, 32'(priv2_o), 32'(p2));
    chk({req, " ie2"},   32'(ie2_o),   32'(e2));
  endtask

  task automatic do_ret();
    ret_req_i = 1'b1;
    tick();
    ret_req_i = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 pc", pc_o, BASE + 32'h100);
    chk_stack("R1", 3, 0, 1, 0, 1, 0);
    chk("R1 trap", 32'(trap_o), 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 mprv", 32'(mprv_o), 0);
    chk("R1 msip", 32'(msip_o), 0);
    chk("R1 mtip", 32'(mtip_o), 0);
  endtask

  task automatic test_m_blocked();
    irq_en_i = 4'b0001;
    ipi_i = 1'b1;
    tick();
    ipi_i = 1'b0;
    chk("R11 ipi sets", 32'(msip_o), 1);
    tick();
    chk("R5 M ie=0 blocks", 32'(trap_o), 0);
    tick();
    chk("R5 M ie=0 blocks later", 32'(trap_o), 0);
    ipi_i = 1'b1; msip_clr_i = 1'b1;
    tick();
    ipi_i = 1'b0; msip_clr_i = 1'b0;
    chk("R11 set wins", 32'(msip_o), 1);
    msip_clr_i = 1'b1;
    tick();
    msip_clr_i = 1'b0;
    chk("R11 clear", 32'(msip_o), 0);
    irq_en_i = '0;
  endtask

  task automatic test_s_level();
    do_ret();
    chk_stack("R3 first pop", 1, 0, 1, 0, 0, 1);
    s_sw_pend_i = 1'b1; irq_en_i = 4'b0100;
    tick(); tick();
    chk("R6 S ie=0 blocks S sw", 32'(trap_o), 0);
    s_sw_pend_i = 1'b0; irq_en_i = '0;
    host_pend_i = 1'b1;
    tick();
    host_pend_i = 1'b0;
    chk("R5 host at S taken", 32'(trap_o), 1);
    chk("R8 host cause", cause_o, 32'h8000_0002);
    chk("R4 vector from S", pc_o, BASE + 32'h40);
    chk_stack("R2 push from S", 3, 0, 1, 0, 1, 0);
    tick();
    chk("R4 strobe one cycle", 32'(trap_o), 0);
    do_ret();
    do_ret();
    chk_stack("R3 second pop", 1, 0, 0, 1, 0, 1);
    do_ret();
    chk_stack("R3 third pop", 0, 1, 0, 1, 0, 1);
  endtask

  task automatic test_exception();
    mprv_set_i = 1'b1;
    tick();
    mprv_set_i = 1'b0;
    chk("R2 mprv set", 32'(mprv_o), 1);
    exc_req_i = 1'b1; exc_cause_i = 31'd5;
    tick();
    exc_req_i = 1'b0;
    chk("R4 exc trap", 32'(trap_o), 1);
    chk("R8 exc cause", cause_o, 32'd5);
    chk("R4 vector from U", pc_o, BASE);
    chk_stack("R2 push from U", 3, 0, 0, 1, 0, 1);
    chk("R2 mprv cleared", 32'(mprv_o), 0);
    tick();
    chk("R4 exc strobe ends", 32'(trap_o), 0);
    do_ret();
    chk_stack("R3 back to U", 0, 1, 0, 1, 0, 1);
  endtask

  task automatic test_priority();
    ipi_i = 1'b1;
    tick();
    ipi_i = 1'b0;
    rtc_i = 32'd20; cmp_we_i = 1'b1; cmp_wdata_i = 32'd10;
    tick();
    cmp_we_i = 1'b0;
    tick();
    chk("R10 mtip set", 32'(mtip_o), 1);
    s_sw_pend_i = 1'b1; s_tm_pend_i = 1'b1;
    tick();
    chk("R12 all masked", 32'(trap_o), 0);
    irq_en_i = 4'b1111;
    tick();
    irq_en_i = '0;
    chk("R7 M sw first", cause_o, 32'h8000_0000);
    chk("R7 trap", 32'(trap_o), 1);
    msip_clr_i = 1'b1;
    tick();
    msip_clr_i = 1'b0;
    do_ret();
    irq_en_i = 4'b1111;
    tick();
    irq_en_i = '0;
    chk("R7 M tm over S sw", cause_o, 32'h8000_0001);
    cmp_we_i = 1'b1; cmp_wdata_i = '1;
    tick();
    cmp_we_i = 1'b0;
    do_ret();
    host_pend_i = 1'b1;
    tick();
    host_pend_i = 1'b0;
    chk("R12 host unmasked", 32'(trap_o), 1);
    chk("R7 host over S", cause_o, 32'h8000_0002);
    do_ret();
    irq_en_i = 4'b1100;
    tick();
    irq_en_i = '0;
    chk("R7 S sw over S tm", cause_o, 32'h8000_0000);
    s_sw_pend_i = 1'b0;
    do_ret();
    irq_en_i = 4'b1000;
    tick();
    irq_en_i = '0;
    chk("R6 S tm at U", cause_o, 32'h8000_0001);
    s_tm_pend_i = 1'b0;
    do_ret();
  endtask

  task automatic test_collisions();
    host_pend_i = 1'b1; exc_req_i = 1'b1; exc_cause_i = 31'd7;
    tick();
    host_pend_i = 1'b0; exc_req_i = 1'b0;
    chk("R9 exc over irq", cause_o, 32'd7);
    do_ret();
    exc_req_i = 1'b1; exc_cause_i = 31'd3; ret_req_i = 1'b1;
    tick();
    exc_req_i = 1'b0; ret_req_i = 1'b0;
    chk("R9 trap over ret priv", 32'(priv_o), 3);
    chk("R9 trap over ret priv1", 32'(priv1_o), 0);
    do_ret();
  endtask

  task automatic test_timer();
    rtc_i = 32'd100; cmp_we_i = 1'b1; cmp_wdata_i = 32'd200;
    tick();
    cmp_we_i = 1'b0;
    chk("R10 write clears", 32'(mtip_o), 0);
    rtc_i = 32'd199;
    tick(); tick();
    chk("R10 below compare", 32'(mtip_o), 0);
    rtc_i = 32'd200;
    tick();
    chk("R10 equal sets", 32'(mtip_o), 1);
    rtc_i = 32'd250; cmp_we_i = 1'b1; cmp_wdata_i = 32'd50;
    tick();
    cmp_we_i = 1'b0;
    chk("R10 write clears when above", 32'(mtip_o), 0);
    tick();
    chk("R10 new value compared", 32'(mtip_o), 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    test_reset();
    test_m_blocked();
    test_s_level();
    test_exception();
    test_priority();
    test_collisions();
    test_timer();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule